// File: doc/BRIEF.md
# Flash Program and Erase Sequencer

This block turns a single high-level request into the full series of serial-flash commands needed to program a span of bytes or erase one sector. It sits above a lower-level engine that does the actual serial shifting. The sequencer tells that engine which opcode to send, whether a 4-byte address follows, how many data bytes to send and whether one status byte is read back. The data bytes are not held here. The lower engine asks for each byte by its index within the current chunk, and the sequencer turns that index into a read address for an external byte buffer.

A program request is cut into page-sized chunks. Before every chunk, and before an erase, the sequencer arms the flash with Write Enable and reads the status byte back to confirm it. It makes a bounded number of attempts. After each program or erase command it polls the status byte until the flash stops reporting busy. Between busy reads it waits, and each wait is one step longer than the one before. It gives up once the accumulated wait reaches a configured limit.

Completion is reported by a one-cycle `done` pulse. `error` is raised in the same cycle when the request failed.

Top module: `flash_prog_seq`

## Requirements
- R1: A program request of L bytes (L > 0) is issued as ceil(L / PAGE_BYTES) program commands. Every chunk is PAGE_BYTES long except the last, which carries the remainder. Chunk i uses address req_addr + i*PAGE_BYTES.
- R2: Before each chunk and before an erase, the block sends Write Enable (opcode 06h, no address, no data) and then Read Status (opcode 05h, one byte read). It repeats this pair until status bit 1 (write-enable latch) reads 1, for at most WEL_TRIES pairs. A latch that is set on the WEL_TRIES-th attempt still succeeds.
- R3: If bit 1 is still 0 after WEL_TRIES pairs, the request ends with `done` and `error`. No program or erase command is sent.
- R4: A chunk is sent as opcode 02h with `cmd_use_addr`=1, the full-width address, and `cmd_wr_len` equal to the chunk length. While the chunk is in flight, `buf_raddr` equals the chunk's byte offset from the start of the request plus `cmd_widx`.
- R5: After each program or erase command, Read Status is repeated until status bit 0 (write in progress) reads 0. The block then moves on to the next chunk, or finishes with `done` and no `error`.
- R6: After the n-th busy status read of one operation, the block waits n*STEP_UNITS*UNIT_CYC cycles before the next read. Two consecutive waits therefore differ by STEP_UNITS*UNIT_CYC cycles.
- R7: The waits are summed in units of UNIT_CYC cycles. If the sum has reached MAX_WAIT when a wait ends, the request ends with `done` and `error` and no further status read is made.
- R8: An erase request sends opcode 20h with `cmd_use_addr`=1, address req_addr and `cmd_wr_len`=0, followed by the same busy polling.
- R9: If any command completes with `cmd_fail`=1, the request ends at once with `done` and `error`, and no further command is started.
- R10: `done` is a one-cycle pulse, and `error` is high only together with `done`.
- R11: A program request with req_len = 0 finishes with `done` and no `error`, without issuing any command.
- R12: `cmd_start` is a one-cycle pulse. A new command starts only after the previous one has reported `cmd_done`.
- R13: After reset, `done`, `error` and `cmd_start` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe; taken only when idle |
| req_erase | input | 1 | 1 = sector erase, 0 = program |
| req_addr | input | ADDR_W | Flash start address |
| req_len | input | LEN_W | Program byte count |
| buf_raddr | output | LEN_W | Byte address into the data buffer |
| cmd_start | output | 1 | Start pulse to the serial command engine |
| cmd_opcode | output | 8 | Command opcode |
| cmd_use_addr | output | 1 | Send a 4-byte address after the opcode |
| cmd_addr | output | ADDR_W | Command address |
| cmd_wr_len | output | $clog2(PAGE_BYTES+1) | Data bytes to send |
| cmd_rd_status | output | 1 | Read one status byte back |
| cmd_widx | input | $clog2(PAGE_BYTES+1) | Index of the data byte the engine wants |
| cmd_done | input | 1 | Command finished (one cycle) |
| cmd_fail | input | 1 | Command failed; valid with cmd_done |
| cmd_rdata | input | 8 | Status byte; valid with cmd_done |
| done | output | 1 | Request finished (one cycle) |
| error | output | 1 | Request failed; valid with done |

## Verification
Assertions check three things on every cycle. Every program command carries a chunk length between 1 and PAGE_BYTES, and non-program commands carry no data. Command starts and completion pulses keep their one-cycle shape, with `error` only alongside `done`. The back-off timer is never restarted while a wait is running, and the address tracker never advances past its final chunk.

Some properties are sequences over many commands, and only the bench scenarios show them. These are the chunk addresses and lengths, the count of write-enable attempts, the exact number of busy reads before a timeout, the growth of the waits between polls, and the silence after a failed command. The bench's simple flash model supplies the status bytes that drive each of these cases.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;
  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_PROG  = 8'h02;
  localparam logic [7:0] OP_ERASE = 8'h20;
  localparam int STS_WIP = 0;
  localparam int STS_WEL = 1;

  typedef enum logic [2:0] {
    S_IDLE,
    S_WREN,
    S_WCHK,
    S_OPER,
    S_POLL,
    S_WAIT
  } seq_state_t;
endpackage

// File: rtl/fseq_chunker.sv
module fseq_chunker #(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 16,
  parameter int PAGE_BYTES = 256,
  localparam int CH_W      = $clog2(PAGE_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [LEN_W-1:0]  ld_len,
  input  logic              advance,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [LEN_W-1:0]  cur_off,
  output logic [CH_W-1:0]   chunk_len,
  output logic              last_chunk
);
  localparam logic [LEN_W-1:0] PAGE_L = LEN_W'(PAGE_BYTES);

  logic [LEN_W-1:0] remain;

  always_comb begin
    if (remain > PAGE_L) chunk_len = CH_W'(PAGE_BYTES);
    else                 chunk_len = remain[CH_W-1:0];
    last_chunk = (remain <= PAGE_L);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_addr <= '0;
      cur_off  <= '0;
      remain   <= '0;
    end else if (load) begin
      cur_addr <= ld_addr;
      cur_off  <= '0;
      remain   <= ld_len;
    end else if (advance) begin
      cur_addr <= cur_addr + ADDR_W'(chunk_len);
      cur_off  <= cur_off + LEN_W'(chunk_len);
      remain   <= remain - LEN_W'(chunk_len);
    end
  end

  // R1: the tracker only steps forward while more than one page is left
  assert_adv_not_last_R1: assert property (@(posedge clk) disable iff (rst)
    advance |-> (remain > PAGE_L))
    else $error("advance on final chunk");
endmodule

// File: rtl/fseq_backoff.sv
module fseq_backoff #(
  parameter int UNIT_CYC   = 50,
  parameter int STEP_UNITS = 100,
  parameter int MAX_WAIT   = 2000000,
  localparam int TOT_W     = $clog2(MAX_WAIT + 2 * STEP_UNITS + 1) + 1,
  localparam int CYC_W     = TOT_W + $clog2(UNIT_CYC + 1) + 1
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic kick,
  output logic fin,
  output logic over
);
  logic [TOT_W-1:0] nstep;
  logic [TOT_W-1:0] total;
  logic [CYC_W-1:0] cnt;
  logic             run;
  logic [TOT_W-1:0] nxt_n;
  logic [TOT_W-1:0] step_u;

  always_comb begin
    nxt_n  = nstep + TOT_W'(1);
    step_u = TOT_W'(nxt_n * TOT_W'(STEP_UNITS));
  end

  assign over = (total >= TOT_W'(MAX_WAIT));

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      nstep <= '0;
      total <= '0;
      cnt   <= '0;
      run   <= 1'b0;
      fin   <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (kick) begin
        nstep <= nxt_n;
        total <= total + step_u;
        cnt   <= CYC_W'(step_u) * CYC_W'(UNIT_CYC);
        run   <= 1'b1;
      end else if (run) begin
        if (cnt <= CYC_W'(1)) begin
          run <= 1'b0;
          fin <= 1'b1;
        end else begin
          cnt <= cnt - CYC_W'(1);
        end
      end
    end
  end

  // R6: a new wait is only started once the previous one has ended
  assert_no_rekick_R6: assert property (@(posedge clk) disable iff (rst)
    kick |-> !run)
    else $error("back-off restarted while running");
endmodule

// File: rtl/flash_prog_seq.sv
module flash_prog_seq
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 16,
  parameter int PAGE_BYTES = 256,
  parameter int WEL_TRIES  = 10,
  parameter int UNIT_CYC   = 50,
  parameter int STEP_UNITS = 100,
  parameter int MAX_WAIT   = 2000000,
  localparam int CH_W      = $clog2(PAGE_BYTES + 1),
  localparam int TRY_W     = $clog2(WEL_TRIES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_erase,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  output logic [LEN_W-1:0]  buf_raddr,
  output logic              cmd_start,
  output logic [7:0]        cmd_opcode,
  output logic              cmd_use_addr,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [CH_W-1:0]   cmd_wr_len,
  output logic              cmd_rd_status,
  input  logic [CH_W-1:0]   cmd_widx,
  input  logic              cmd_done,
  input  logic              cmd_fail,
  input  logic [7:0]        cmd_rdata,
  output logic              done,
  output logic              error
);
  seq_state_t        state;
  logic              pend;
  logic [TRY_W-1:0]  tries;
  logic              is_erase;

  logic              rsp_ok, rsp_bad, wip, wel;
  logic              chk_load, chk_adv, bo_clr, bo_kick, bo_fin, bo_over;
  logic [ADDR_W-1:0] cur_addr;
  logic [LEN_W-1:0]  cur_off;
  logic [CH_W-1:0]   chunk_len;
  logic              last_chunk;
  logic [5:0]        unused_sts;

  assign unused_sts = cmd_rdata[7:2];

  always_comb begin
    rsp_ok   = pend && cmd_done && !cmd_fail;
    rsp_bad  = pend && cmd_done && cmd_fail;
    wip      = cmd_rdata[STS_WIP];
    wel      = cmd_rdata[STS_WEL];
    chk_load = (state == S_IDLE) && req_valid;
    bo_clr   = (state == S_OPER) && rsp_ok;
    bo_kick  = (state == S_POLL) && rsp_ok && wip;
    chk_adv  = (state == S_POLL) && rsp_ok && !wip && !is_erase && !last_chunk;
  end

  assign buf_raddr = cur_off + LEN_W'(cmd_widx);

  fseq_chunker #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .PAGE_BYTES(PAGE_BYTES)
  ) u_chunk (
    .clk(clk), .rst(rst), .load(chk_load), .ld_addr(req_addr), .ld_len(req_len),
    .advance(chk_adv), .cur_addr(cur_addr), .cur_off(cur_off),
    .chunk_len(chunk_len), .last_chunk(last_chunk)
  );

  fseq_backoff #(
    .UNIT_CYC(UNIT_CYC), .STEP_UNITS(STEP_UNITS), .MAX_WAIT(MAX_WAIT)
  ) u_backoff (
    .clk(clk), .rst(rst), .clr(bo_clr), .kick(bo_kick), .fin(bo_fin), .over(bo_over)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= S_IDLE;
      pend          <= 1'b0;
      tries         <= '0;
      is_erase      <= 1'b0;
      cmd_start     <= 1'b0;
      cmd_opcode    <= '0;
      cmd_use_addr  <= 1'b0;
      cmd_addr      <= '0;
      cmd_wr_len    <= '0;
      cmd_rd_status <= 1'b0;
      done          <= 1'b0;
      error         <= 1'b0;
    end else begin
      cmd_start <= 1'b0;
      done      <= 1'b0;
      error     <= 1'b0;
      if (state != S_IDLE && rsp_bad) begin
        pend  <= 1'b0;
        done  <= 1'b1;
        error <= 1'b1;
        state <= S_IDLE;
      end else begin
        case (state)
          S_IDLE: if (req_valid) begin
            is_erase <= req_erase;
            tries    <= '0;
            if (!req_erase && req_len == '0) done <= 1'b1;
            else                             state <= S_WREN;
          end
          S_WREN: if (!pend) begin
            cmd_start     <= 1'b1;
            cmd_opcode    <= OP_WREN;
            cmd_use_addr  <= 1'b0;
            cmd_wr_len    <= '0;
            cmd_rd_status <= 1'b0;
            pend          <= 1'b1;
          end else if (rsp_ok) begin
            pend  <= 1'b0;
            state <= S_WCHK;
          end
          S_WCHK: if (!pend) begin
            cmd_start     <= 1'b1;
            cmd_opcode    <= OP_RDSR;
            cmd_use_addr  <= 1'b0;
            cmd_wr_len    <= '0;
            cmd_rd_status <= 1'b1;
            pend          <= 1'b1;
          end else if (rsp_ok) begin
            pend <= 1'b0;
            if (wel) begin
              state <= S_OPER;
            end else if (tries == TRY_W'(WEL_TRIES - 1)) begin
              done  <= 1'b1;
              error <= 1'b1;
              state <= S_IDLE;
            end else begin
              tries <= tries + TRY_W'(1);
              state <= S_WREN;
            end
          end
          S_OPER: if (!pend) begin
            cmd_start     <= 1'b1;
            cmd_opcode    <= is_erase ? OP_ERASE : OP_PROG;
            cmd_use_addr  <= 1'b1;
            cmd_addr      <= cur_addr;
            cmd_wr_len    <= is_erase ? '0 : chunk_len;
            cmd_rd_status <= 1'b0;
            pend          <= 1'b1;
          end else if (rsp_ok) begin
            pend  <= 1'b0;
            state <= S_POLL;
          end
          S_POLL: if (!pend) begin
            cmd_start     <= 1'b1;
            cmd_opcode    <= OP_RDSR;
            cmd_use_addr  <= 1'b0;
            cmd_wr_len    <= '0;
            cmd_rd_status <= 1'b1;
            pend          <= 1'b1;
          end else if (rsp_ok) begin
            pend <= 1'b0;
            if (wip) begin
              state <= S_WAIT;
            end else if (is_erase || last_chunk) begin
              done  <= 1'b1;
              state <= S_IDLE;
            end else begin
              tries <= '0;
              state <= S_WREN;
            end
          end
          S_WAIT: if (bo_fin) begin
            if (bo_over) begin
              done  <= 1'b1;
              error <= 1'b1;
              state <= S_IDLE;
            end else begin
              state <= S_POLL;
            end
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  // R1: program commands carry a non-empty chunk no larger than a page
  assert_chunk_bound_R1: assert property (@(posedge clk) disable iff (rst)
    (cmd_start && cmd_opcode == OP_PROG) |-> (cmd_wr_len != '0 && cmd_wr_len <= CH_W'(PAGE_BYTES)))
    else $error("chunk length out of range");

  // R8: every command other than program sends no data bytes
  assert_no_data_R8: assert property (@(posedge clk) disable iff (rst)
    (cmd_start && cmd_opcode != OP_PROG) |-> (cmd_wr_len == '0))
    else $error("data attached to non-program command");

  // R10: error only accompanies done
  assert_err_with_done_R10: assert property (@(posedge clk) disable iff (rst)
    error |-> done)
    else $error("error without done");

  // R12: command start is a single-cycle pulse
  assert_start_pulse_R12: assert property (@(posedge clk) disable iff (rst)
    cmd_start |=> !cmd_start)
    else $error("start held high");
endmodule

// File: tb/flash_prog_seq_test.sv
module flash_prog_seq_test;
  localparam int ADDR_W = 32;
  localparam int LEN_W  = 12;
  localparam int PAGE   = 256;
  localparam int TRIES  = 10;
  localparam int UNIT   = 3;
  localparam int STEP   = 2;
  localparam int MAXW   = 20;
  localparam int CH_W   = $clog2(PAGE + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_erase = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [LEN_W-1:0]  req_len = '0;
  logic [LEN_W-1:0]  buf_raddr;
  logic cmd_start, cmd_use_addr, cmd_rd_status;
  logic [7:0] cmd_opcode;
  logic [ADDR_W-1:0] cmd_addr;
  logic [CH_W-1:0] cmd_wr_len;
  logic [CH_W-1:0] cmd_widx = '0;
  logic cmd_done = 1'b0, cmd_fail = 1'b0;
  logic [7:0] cmd_rdata = '0;
  logic done, error;

  always #10 clk = ~clk;

  flash_prog_seq #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .PAGE_BYTES(PAGE), .WEL_TRIES(TRIES),
    .UNIT_CYC(UNIT), .STEP_UNITS(STEP), .MAX_WAIT(MAXW)
  ) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_erase(req_erase),
    .req_addr(req_addr), .req_len(req_len), .buf_raddr(buf_raddr),
    .cmd_start(cmd_start), .cmd_opcode(cmd_opcode), .cmd_use_addr(cmd_use_addr),
    .cmd_addr(cmd_addr), .cmd_wr_len(cmd_wr_len), .cmd_rd_status(cmd_rd_status),
    .cmd_widx(cmd_widx), .cmd_done(cmd_done), .cmd_fail(cmd_fail),
    .cmd_rdata(cmd_rdata), .done(done), .error(error)
  );

  int total = 0, bad = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // flash model knobs and logs
  int wel_fail, busy_n, fail_at;
  int ncmd, n_wren, n_rdsr, n_prog, n_erase, np, wel_seen, busy_seen;
  logic [7:0] last_op;
  logic [ADDR_W-1:0] base;
  logic [ADDR_W-1:0] p_addr [16];
  int p_len [16];
  int poll_t [16];
  logic [ADDR_W-1:0] e_addr;
  int e_len;
  int bad_fmt;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_chunks(input int len);
    return (len + PAGE - 1) / PAGE;
  endfunction

  function automatic int exp_clen(input int len, input int i);
    return (i == exp_chunks(len) - 1) ? len - PAGE * i : PAGE;
  endfunction

  // responder modelling the serial engine plus flash
  initial begin
    forever begin
      @(negedge clk);
      if (cmd_start && !rst) begin
        automatic int idx = ncmd;
        automatic logic [7:0] sts = 8'h00;
        automatic logic [7:0] op = cmd_opcode;
        ncmd++;
        case (op)
          8'h06: begin
            n_wren++; last_op = op;
            if (cmd_use_addr || cmd_wr_len != 0) bad_fmt++;
          end
          8'h05: begin
            n_rdsr++;
            if (!cmd_rd_status || cmd_use_addr) bad_fmt++;
            if (last_op == 8'h06) begin
              sts = (wel_seen < wel_fail) ? 8'h00 : 8'h02;
              wel_seen++;
            end else begin
              if (np < 16) poll_t[np] = cyc;
              np++;
              sts = (busy_seen < busy_n) ? 8'h03 : 8'h00;
              busy_seen++;
            end
          end
          8'h02: begin
            if (n_prog < 16) begin
              p_addr[n_prog] = cmd_addr;
              p_len[n_prog] = int'(cmd_wr_len);
            end
            n_prog++; last_op = op; wel_seen = 0; busy_seen = 0;
            if (!cmd_use_addr) bad_fmt++;
          end
          8'h20: begin
            e_addr = cmd_addr; e_len = int'(cmd_wr_len);
            n_erase++; last_op = op; wel_seen = 0; busy_seen = 0;
            if (!cmd_use_addr) bad_fmt++;
          end
          default: bad_fmt++;
        endcase
        @(negedge clk);
        if (op == 8'h02 && cmd_wr_len != 0) begin
          automatic logic [CH_W-1:0] wi = CH_W'($urandom_range(int'(cmd_wr_len) - 1));
          automatic logic [LEN_W-1:0] ex;
          cmd_widx = wi;
          @(negedge clk);
          ex = LEN_W'(cmd_addr - base) + LEN_W'(wi);
          chk(buf_raddr == ex, "R4 buffer address", buf_raddr, ex);
        end else begin
          @(negedge clk);
        end
        cmd_rdata = sts;
        cmd_fail = (idx == fail_at);
        cmd_done = 1'b1;
        @(negedge clk);
        cmd_done = 1'b0;
        cmd_fail = 1'b0;
      end
    end
  end

  task automatic run_req(input bit er, input logic [ADDR_W-1:0] a, input int len,
                         input int wf, input int bn, input int fa, output bit got_err);
    bit seen = 0;
    wel_fail = wf; busy_n = bn; fail_at = fa;
    ncmd = 0; n_wren = 0; n_rdsr = 0; n_prog = 0; n_erase = 0; np = 0;
    wel_seen = 0; busy_seen = 0; last_op = 8'h00; base = a; bad_fmt = 0;
    e_addr = '0; e_len = -1; got_err = 0;
    @(negedge clk);
    req_valid = 1'b1; req_erase = er; req_addr = a; req_len = LEN_W'(len);
    for (int t = 0; t < 6000; t++) begin
      @(negedge clk);
      req_valid = 1'b0;
      if (done) begin seen = 1; got_err = error; break; end
    end
    chk(seen, "R10 done within limit", seen, 1);
    repeat (4) @(negedge clk);
  endtask

  task automatic check_prog(input logic [ADDR_W-1:0] a, input int len, input int wf, input int bn);
    bit e;
    int c;
    run_req(1'b0, a, len, wf, bn, -1, e);
    c = exp_chunks(len);
    chk(!e, "R5 no error", e, 0);
    chk(n_prog == c, "R1 chunk count", n_prog, c);
    chk(n_wren == c * (wf + 1), "R2 write enable count", n_wren, c * (wf + 1));
    chk(n_rdsr == c * (wf + 1) + c * (bn + 1), "R5 status read count", n_rdsr, c * (wf + 2 + bn));
    chk(bad_fmt == 0, "R4 command format", bad_fmt, 0);
    for (int i = 0; i < c && i < 16; i++) begin
      chk(p_addr[i] == a + ADDR_W'(PAGE * i), "R1 chunk address", p_addr[i], a + ADDR_W'(PAGE * i));
      chk(p_len[i] == exp_clen(len, i), "R4 chunk length", p_len[i], exp_clen(len, i));
    end
  endtask

  initial begin
    bit e;
    void'($urandom(32'd4242));
    wel_fail = 0; busy_n = 0; fail_at = -1; last_op = 0; bad_fmt = 0;
    ncmd = 0; n_wren = 0; n_rdsr = 0; n_prog = 0; n_erase = 0; np = 0;
    repeat (5) @(negedge clk);
    chk(done == 0, "R13 reset done", done, 0);
    chk(error == 0, "R13 reset error", error, 0);
    chk(cmd_start == 0, "R13 reset start", cmd_start, 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    // directed programs
    check_prog(32'h0000_0100, 1, 0, 0);
    check_prog(32'h0100_0000, 256, 2, 1);
    check_prog(32'h0020_0000, 257, 0, 0);
    check_prog(32'h0000_1000, 512, 1, 2);
    // R2: latch appears on the last allowed attempt
    check_prog(32'h0000_2000, 5, TRIES - 1, 0);

    // R8 erase with three busy reads; R6 growing waits
    run_req(1'b1, 32'h00AB_0000, 0, 1, 3, -1, e);
    chk(!e, "R8 erase no error", e, 0);
    chk(n_erase == 1, "R8 erase count", n_erase, 1);
    chk(n_prog == 0, "R8 no program", n_prog, 0);
    chk(e_addr == 32'h00AB_0000, "R8 erase address", e_addr, 32'h00AB_0000);
    chk(e_len == 0, "R8 erase no data", e_len, 0);
    chk(np == 4, "R5 erase poll count", np, 4);
    chk((poll_t[2] - poll_t[1]) - (poll_t[1] - poll_t[0]) == STEP * UNIT, "R6 wait growth 1",
        (poll_t[2] - poll_t[1]) - (poll_t[1] - poll_t[0]), STEP * UNIT);
    chk((poll_t[3] - poll_t[2]) - (poll_t[2] - poll_t[1]) == STEP * UNIT, "R6 wait growth 2",
        (poll_t[3] - poll_t[2]) - (poll_t[2] - poll_t[1]), STEP * UNIT);
    chk(poll_t[1] - poll_t[0] > STEP * UNIT, "R6 first wait length", poll_t[1] - poll_t[0], STEP * UNIT);

    // R7 timeout: waits of 2,4,6,8 units reach 20 after the 4th busy read
    run_req(1'b0, 32'h0000_0400, 10, 0, 100, -1, e);
    chk(e, "R7 timeout error", e, 1);
    chk(np == 4, "R7 busy reads before timeout", np, 4);
    chk(n_prog == 1, "R7 single program", n_prog, 1);

    // R3 write enable never latched
    run_req(1'b0, 32'h0000_0800, 300, 100, 0, -1, e);
    chk(e, "R3 error", e, 1);
    chk(n_wren == TRIES, "R3 attempt count", n_wren, TRIES);
    chk(n_prog + n_erase == 0, "R3 no program", n_prog + n_erase, 0);
    run_req(1'b1, 32'h0000_0800, 0, 100, 0, -1, e);
    chk(e && n_erase == 0, "R3 no erase", n_erase, 0);

    // R9 failures at several command positions
    for (int k = 0; k < 6; k++) begin
      run_req(1'b0, 32'h0003_0000, 300, 0, 1, k, e);
      chk(e, "R9 error on fail", e, 1);
      chk(ncmd == k + 1, "R9 no command after fail", ncmd, k + 1);
    end

    // R11 zero-length program
    run_req(1'b0, 32'h0000_0000, 0, 0, 0, -1, e);
    chk(!e, "R11 no error", e, 0);
    chk(ncmd == 0, "R11 no commands", ncmd, 0);

    // random programs
    for (int r = 0; r < 8; r++) begin
      automatic int len = $urandom_range(900, 1);
      automatic logic [ADDR_W-1:0] a = $urandom();
      check_prog(a, len, $urandom_range(3), $urandom_range(3));
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    total++;
    bad++;
    $display("FAIL watchdog act=%0d exp=%0d", cyc, 150000);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule